// File: doc/BRIEF.md
# Hierarchical ECC Error Event Counter

This block tallies error events reported by a set of monitored hardware sub-blocks. Each event is a single-cycle pulse that carries the index of the reporting sub-block and a kind bit. The kind bit marks the error as either correctable or uncorrectable. For every sub-block the block keeps one correctable counter and one uncorrectable counter. It also keeps two instance-wide totals, one for each kind. All counters are read through a registered read port. A write strobe with no data clears them all at once.

Policy inputs decide what the block does with each event. There is a separate log enable for each error kind. The log enables gate only the log-request strobe. Counting continues whether or not logging is enabled. When the panic-on-uncorrectable input is set, an uncorrectable event drives a sticky panic output. That event is not counted.

A prescaler divides the system clock into milliseconds. The millisecond count then sets the period of a poll tick, whose length in milliseconds is programmable. A program value of zero selects the built-in default of 1000 ms.

Top module: `ecc_evt_tally`

## Requirements
- R1: A valid event with `evt_uncorr`=0 increments the correctable counter of sub-block `evt_unit`, and one with `evt_uncorr`=1 increments its uncorrectable counter. Read address u (0..N_UNITS-1) returns the correctable count of sub-block u. Address N_UNITS+u returns its uncorrectable count.
- R2: Read address 2*N_UNITS returns the correctable total and 2*N_UNITS+1 returns the uncorrectable total. Each total always equals the sum of the per-sub-block counters of its kind.
- R3: Events for the same sub-block and kind on consecutive cycles are each counted exactly once.
- R4: An accepted event (valid with no clear in the same cycle) raises `log_req` for exactly the following cycle, but only when the enable for its kind is set. When it does, `log_is_ue` equals the event kind. Counting does not depend on the log enables.
- R5: A per-sub-block counter stops at 2^CNT_W-1 and does not wrap. An event that hits a stopped counter also leaves the total unchanged.
- R6: An uncorrectable event seen while `panic_ue_en`=1 sets `panic` on the next cycle and does not change any uncorrectable counter. `panic` then stays high until reset. The clear strobe does not lower it.
- R7: `clr_we`=1 sets every counter to zero on the next cycle. An event in the same cycle is neither counted nor logged.
- R8: `poll_tick` is a one-cycle pulse that repeats every P*CLKS_PER_MS cycles. P is `poll_ms`, or DEFAULT_POLL_MS (1000) when `poll_ms` is 0.
- R9: After reset all counters read zero and `log_req`, `log_is_ue` and `panic` are low.
- R10: `rd_data` shows the value at `rd_addr` one cycle after the address is presented. Addresses above 2*N_UNITS+1 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event pulse |
| evt_unit | input | UIDX_W | Index of the reporting sub-block |
| evt_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| log_ce_en | input | 1 | Log enable for correctable events |
| log_ue_en | input | 1 | Log enable for uncorrectable events |
| panic_ue_en | input | 1 | Panic on uncorrectable events |
| poll_ms | input | PW | Poll period in ms, 0 selects the default |
| clr_we | input | 1 | Write strobe that clears all counters |
| rd_addr | input | AW | Counter read address |
| rd_data | output | TOT_W | Registered read data |
| log_req | output | 1 | Log-request strobe |
| log_is_ue | output | 1 | Kind of the logged event |
| panic | output | 1 | Sticky panic indication |
| poll_tick | output | 1 | Periodic poll pulse |

## Verification
A counter that misses, repeats or wraps an increment becomes visible on the read port. It appears at both the sub-block address and the matching total as soon as that address is read, one cycle after it is presented. A total that drifts from the sum of its sub-blocks differs from the model sum on the next full read sweep. Errors in log or panic gating show up on `log_req`, `log_is_ue` or `panic` one cycle after the offending event. A prescaler fault shifts the spacing of `poll_tick` by whole cycles between two consecutive pulses.

// File: rtl/ecc_evt_pkg.sv
package ecc_evt_pkg;
  // kind bit carried by every event
  typedef enum logic {
    KIND_CE = 1'b0,
    KIND_UE = 1'b1
  } evt_kind_e;

  // read address of the correctable total; the uncorrectable one follows it
  function automatic int unsigned tot_base(input int unsigned n_units);
    return 2 * n_units;
  endfunction
endpackage

// File: rtl/ecc_evt_bank.sv
// One counter per sub-block for a single error kind, saturating.
module ecc_evt_bank #(
  parameter int N_UNITS = 4,
  parameter int CNT_W   = 16,
  parameter int UIDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              hit,
  input  logic [UIDX_W-1:0] unit,
  output logic [CNT_W-1:0]  cnt_o [N_UNITS],
  output logic              inc_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // an increment actually lands only if the selected counter has room
  always_comb begin
    inc_o = 1'b0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (unit == UIDX_W'(i)) inc_o = hit && (cnt_o[i] != CNT_MAX);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_UNITS; i++) begin
      if (rst || clr) begin
        cnt_o[i] <= '0;
      end else if (hit && (unit == UIDX_W'(i)) && (cnt_o[i] != CNT_MAX)) begin
        cnt_o[i] <= cnt_o[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_UNITS; g++) begin : g_chk
    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_o[g] == CNT_MAX && !clr) |=> (cnt_o[g] == CNT_MAX));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && hit && unit == UIDX_W'(g) && cnt_o[g] != CNT_MAX)
        |=> (cnt_o[g] == $past(cnt_o[g]) + 1'b1));
  end
endmodule

// File: rtl/ecc_evt_total.sv
// Instance-wide accumulator advanced by the bank's landed increments.
module ecc_evt_total #(
  parameter int TOT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [TOT_W-1:0] tot_o
);
  always_ff @(posedge clk) begin
    if (rst || clr)  tot_o <= '0;
    else if (inc)    tot_o <= tot_o + 1'b1;
  end

  // R7
  tot_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tot_o == '0));
endmodule

// File: rtl/ecc_evt_poll.sv
// Millisecond prescaler followed by a programmable period counter.
module ecc_evt_poll #(
  parameter int CLKS_PER_MS     = 100000,
  parameter int PW              = 16,
  parameter int DEFAULT_POLL_MS = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] poll_ms,
  output logic          tick_o
);
  localparam int PRE_W = $clog2(CLKS_PER_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);
  localparam logic [PW-1:0]    DEF_P    = PW'(DEFAULT_POLL_MS);

  logic [PRE_W-1:0] pre_q;
  logic [PW-1:0]    ms_q;
  logic [PW-1:0]    period;
  logic             ms_wrap;
  logic             last_ms;

  assign period  = (poll_ms == '0) ? DEF_P : poll_ms;
  assign ms_wrap = (pre_q == PRE_LAST);
  assign last_ms = (ms_q >= period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      ms_q   <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (ms_wrap) begin
        pre_q <= '0;
        if (last_ms) begin
          ms_q   <= '0;
          tick_o <= 1'b1;
        end else begin
          ms_q <= ms_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R8
  tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && (CLKS_PER_MS > 1)) |=> !tick_o);
endmodule

// File: rtl/ecc_evt_policy.sv
// Log strobe and sticky panic, all registered.
module ecc_evt_policy (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic is_ue,
  input  logic log_ce_en,
  input  logic log_ue_en,
  input  logic panic_ue_en,
  output logic log_req,
  output logic log_is_ue,
  output logic panic
);
  logic want_log;
  assign want_log = acc && (is_ue ? log_ue_en : log_ce_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      log_req   <= 1'b0;
      log_is_ue <= 1'b0;
      panic     <= 1'b0;
    end else begin
      log_req   <= want_log;
      log_is_ue <= want_log && is_ue;
      if (acc && is_ue && panic_ue_en) panic <= 1'b1;
    end
  end

  // R4
  log_gate_chk: assert property (@(posedge clk) disable iff (rst)
    log_req |-> $past(acc));
  // R6
  panic_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    panic |=> panic);
endmodule

// File: rtl/ecc_evt_tally.sv
module ecc_evt_tally
  import ecc_evt_pkg::*;
#(
  parameter int N_UNITS         = 4,
  parameter int CNT_W           = 16,
  parameter int CLKS_PER_MS     = 100000,
  parameter int PW              = 16,
  parameter int DEFAULT_POLL_MS = 1000,
  localparam int UIDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  localparam int TOT_W  = CNT_W + UIDX_W,
  localparam int AW     = $clog2(2 * N_UNITS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [UIDX_W-1:0] evt_unit,
  input  logic              evt_uncorr,
  input  logic              log_ce_en,
  input  logic              log_ue_en,
  input  logic              panic_ue_en,
  input  logic [PW-1:0]     poll_ms,
  input  logic              clr_we,
  input  logic [AW-1:0]     rd_addr,
  output logic [TOT_W-1:0]  rd_data,
  output logic              log_req,
  output logic              log_is_ue,
  output logic              panic,
  output logic              poll_tick
);
  localparam int TBASE = tot_base(N_UNITS);

  logic             accept;
  logic             ce_hit;
  logic             ue_hit;
  logic             ce_inc;
  logic             ue_inc;
  logic [CNT_W-1:0] ce_cnt [N_UNITS];
  logic [CNT_W-1:0] ue_cnt [N_UNITS];
  logic [TOT_W-1:0] ce_tot;
  logic [TOT_W-1:0] ue_tot;
  logic [TOT_W-1:0] rd_next;

  assign accept = evt_valid && !clr_we;
  assign ce_hit = accept && (evt_uncorr == KIND_CE);
  // a panicking uncorrectable event never reaches its counter
  assign ue_hit = accept && (evt_uncorr == KIND_UE) && !panic_ue_en;

  ecc_evt_bank #(.N_UNITS(N_UNITS), .CNT_W(CNT_W), .UIDX_W(UIDX_W)) u_ce_bank (
    .clk(clk), .rst(rst), .clr(clr_we), .hit(ce_hit), .unit(evt_unit),
    .cnt_o(ce_cnt), .inc_o(ce_inc)
  );

  ecc_evt_bank #(.N_UNITS(N_UNITS), .CNT_W(CNT_W), .UIDX_W(UIDX_W)) u_ue_bank (
    .clk(clk), .rst(rst), .clr(clr_we), .hit(ue_hit), .unit(evt_unit),
    .cnt_o(ue_cnt), .inc_o(ue_inc)
  );

  ecc_evt_total #(.TOT_W(TOT_W)) u_ce_tot (
    .clk(clk), .rst(rst), .clr(clr_we), .inc(ce_inc), .tot_o(ce_tot)
  );

  ecc_evt_total #(.TOT_W(TOT_W)) u_ue_tot (
    .clk(clk), .rst(rst), .clr(clr_we), .inc(ue_inc), .tot_o(ue_tot)
  );

  ecc_evt_policy u_policy (
    .clk(clk), .rst(rst), .acc(accept), .is_ue(evt_uncorr),
    .log_ce_en(log_ce_en), .log_ue_en(log_ue_en), .panic_ue_en(panic_ue_en),
    .log_req(log_req), .log_is_ue(log_is_ue), .panic(panic)
  );

  ecc_evt_poll #(
    .CLKS_PER_MS(CLKS_PER_MS), .PW(PW), .DEFAULT_POLL_MS(DEFAULT_POLL_MS)
  ) u_poll (
    .clk(clk), .rst(rst), .poll_ms(poll_ms), .tick_o(poll_tick)
  );

  // read decode: per-unit correctable, per-unit uncorrectable, then totals
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (rd_addr == AW'(i))           rd_next = TOT_W'(ce_cnt[i]);
      if (rd_addr == AW'(N_UNITS + i)) rd_next = TOT_W'(ue_cnt[i]);
    end
    if (rd_addr == AW'(TBASE))     rd_next = ce_tot;
    if (rd_addr == AW'(TBASE + 1)) rd_next = ue_tot;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // sums of the banks, used only to cross-check the separate totals
  logic [TOT_W-1:0] ce_sum;
  logic [TOT_W-1:0] ue_sum;
  always_comb begin
    ce_sum = '0;
    ue_sum = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      ce_sum = ce_sum + TOT_W'(ce_cnt[i]);
      ue_sum = ue_sum + TOT_W'(ue_cnt[i]);
    end
  end

  // R2
  tot_ce_sum_chk: assert property (@(posedge clk) disable iff (rst)
    ce_tot == ce_sum);
  // R2
  tot_ue_sum_chk: assert property (@(posedge clk) disable iff (rst)
    ue_tot == ue_sum);
  // R6
  ue_panic_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_uncorr && panic_ue_en && !clr_we) |=> ($stable(ue_tot) && panic));
endmodule

// File: tb/ecc_evt_tally_bench.sv
module ecc_evt_tally_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int CW   = 4;
  localparam int CPM  = 4;
  localparam int PW   = 16;
  localparam int UW   = 2;
  localparam int TW   = CW + UW;
  localparam int AW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt_valid = 1'b0;
  logic [UW-1:0] evt_unit = '0;
  logic          evt_uncorr = 1'b0;
  logic          log_ce_en = 1'b0;
  logic          log_ue_en = 1'b0;
  logic          panic_ue_en = 1'b0;
  logic [PW-1:0] poll_ms = 16'd3;
  logic          clr_we = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [TW-1:0] rd_data;
  logic          log_req;
  logic          log_is_ue;
  logic          panic;
  logic          poll_tick;

  int n_chk = 0;
  int n_bad = 0;
  int ce_m [N];
  int ue_m [N];
  int exp_panic = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_evt_tally #(
    .N_UNITS(N), .CNT_W(CW), .CLKS_PER_MS(CPM), .PW(PW), .DEFAULT_POLL_MS(1000)
  ) u_ecc_evt_tally (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_unit(evt_unit),
    .evt_uncorr(evt_uncorr), .log_ce_en(log_ce_en), .log_ue_en(log_ue_en),
    .panic_ue_en(panic_ue_en), .poll_ms(poll_ms), .clr_we(clr_we),
    .rd_addr(rd_addr), .rd_data(rd_data), .log_req(log_req),
    .log_is_ue(log_is_ue), .panic(panic), .poll_tick(poll_tick)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  function automatic int expect_at(input int a);
    int s;
    if (a < N) return ce_m[a];
    if (a < 2*N) return ue_m[a-N];
    s = 0;
    if (a == 2*N)   begin for (int i = 0; i < N; i++) s += ce_m[i]; return s; end
    if (a == 2*N+1) begin for (int i = 0; i < N; i++) s += ue_m[i]; return s; end
    return 0;
  endfunction

  // one cycle of stimulus, with the log and panic outputs checked afterwards
  task automatic send(input bit v, input int u, input bit ue, input bit clr);
    bit exp_log;
    @(negedge clk);
    evt_valid  = v;
    evt_unit   = UW'(u);
    evt_uncorr = ue;
    clr_we     = clr;
    @(posedge clk); #1;
    exp_log = v && !clr && (ue ? log_ue_en : log_ce_en);
    if (clr) begin
      for (int i = 0; i < N; i++) begin ce_m[i] = 0; ue_m[i] = 0; end
    end else if (v) begin
      if (!ue)              ce_m[u] = sat_inc(ce_m[u]);
      else if (!panic_ue_en) ue_m[u] = sat_inc(ue_m[u]);
      else                  exp_panic = 1;
    end
    chk("R4 log_req", int'(log_req), int'(exp_log));
    if (exp_log) chk("R4 log_is_ue", int'(log_is_ue), int'(ue));
    chk("R6 panic", int'(panic), exp_panic);
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk);
    evt_valid = 1'b0;
    clr_we    = 1'b0;
    rd_addr   = AW'(a);
    @(posedge clk); #1;
    chk(req, int'(rd_data), expect_at(a));
  endtask

  task automatic sweep();
    for (int a = 0; a < N; a++)   rd_chk(a, "R1 ce count");
    for (int a = N; a < 2*N; a++) rd_chk(a, "R1 ue count");
    rd_chk(2*N,   "R2 ce total");
    rd_chk(2*N+1, "R2 ue total");
    rd_chk(15,    "R10 unused address");
  endtask

  task automatic poll_chk(input int ms, input int exp_gap, input string req);
    int gap;
    @(negedge clk);
    evt_valid = 1'b0;
    poll_ms = PW'(ms);
    gap = 0;
    while (!poll_tick && gap < 20000) begin @(posedge clk); #1; gap++; end
    gap = 0;
    do begin
      @(posedge clk); #1;
      gap++;
      if (gap == 1) chk("R8 tick width", int'(poll_tick), 0);
    end while (!poll_tick && gap < 20000);
    chk(req, gap, exp_gap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7341);
    for (int i = 0; i < N; i++) begin ce_m[i] = 0; ue_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R9 reset state
    chk("R9 log_req", int'(log_req), 0);
    chk("R9 log_is_ue", int'(log_is_ue), 0);
    chk("R9 panic", int'(panic), 0);
    sweep();

    // R1 directed: one event of each kind per unit, logs on
    log_ce_en = 1'b1; log_ue_en = 1'b1;
    for (int u = 0; u < N; u++) begin
      send(1, u, 0, 0);
      send(1, u, 1, 0);
    end
    sweep();

    // R3 back-to-back hits on one counter
    send(0, 0, 0, 1);
    for (int k = 0; k < 3; k++) send(1, 1, 1, 0);
    send(0, 0, 0, 0);
    rd_chk(N+1, "R3 consecutive ue");
    rd_chk(2*N+1, "R3 ue total");

    // R4 logs disabled, counting continues
    log_ce_en = 1'b0; log_ue_en = 1'b0;
    send(1, 2, 0, 0);
    send(1, 3, 1, 0);
    rd_chk(2, "R4 ce counted with log off");
    rd_chk(N+3, "R4 ue counted with log off");

    // R7 clear together with an event
    send(1, 0, 0, 1);
    sweep();

    // R5 saturation
    for (int k = 0; k < CMAX + 5; k++) send(1, 2, 0, 0);
    rd_chk(2, "R5 saturated count");
    rd_chk(2*N, "R5 total at saturation");

    // random mix, panic off
    for (int k = 0; k < 600; k++) begin
      log_ce_en = 1'($urandom_range(0, 1));
      log_ue_en = 1'($urandom_range(0, 1));
      send(1'($urandom_range(0, 3) != 0), $urandom_range(0, N-1),
           1'($urandom_range(0, 1)), ($urandom_range(0, 99) == 0));
      if (k % 100 == 99) sweep();
    end
    sweep();

    // R6 panic on uncorrectable
    log_ue_en = 1'b1;
    panic_ue_en = 1'b1;
    send(1, 0, 1, 0);
    send(1, 1, 1, 0);
    send(1, 1, 0, 0);
    sweep();
    send(0, 0, 0, 1);
    chk("R6 panic kept over clear", int'(panic), 1);
    panic_ue_en = 1'b0;

    // R8 poll period, programmed and default
    poll_chk(3, 3*CPM, "R8 period 3 ms");
    poll_chk(1, 1*CPM, "R8 period 1 ms");
    poll_chk(0, 1000*CPM, "R8 default period");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule